// File: doc/BRIEF.md
# Bit-Test Execution Unit

This unit carries out the bit-test instruction of a processor whose accumulator is either 8 or 16 bits wide. A sequencer pulses `start` with the opcode byte, the operand bytes that follow it and a snapshot of the accumulator, X, the direct page register, the data bank and the status byte. The unit decodes the addressing mode and forms the effective address. It reads the operand through a byte-wide read port with combinational return data, in one or two bus cycles. It then tests the operand against the accumulator and writes back the status byte.

The unit spends one state per bus cycle, with the start cycle counted as cycle 1. For each addressing mode and each penalty condition it uses exactly the number of cycles listed below. In the cycle after its last one it presents a one-cycle `done` together with the new status byte and the instruction length. A new `start` may come in that same cycle. The accumulator is only an input and is never written.

Top module: `bittest_unit`

## Requirements
- R1: Opcodes 0x89 (immediate), 0x24 (direct page), 0x34 (direct page + X), 0x2C (absolute) and 0x3C (absolute + X) begin execution when `start` is high while idle. Any other opcode is ignored: there is no read, no `done`, and `pOut` is unchanged.
- R2: Z (status bit 1) is set exactly when the bitwise AND of the accumulator and the operand is zero. The test covers 16 bits when `wideAcc` was high at start and the low 8 bits otherwise.
- R3: In the four memory modes, N (status bit 7) takes the operand's top bit (bit 15 when wide, bit 7 otherwise) and V (status bit 6) takes the bit just below it.
- R4: In immediate mode, N and V keep their values from `pIn`. The operand is `opLo`, or {`opHi`,`opLo`} when wide, and no memory read is made.
- R5: Status bits 5, 4, 3, 2 and 0 of `pOut` repeat `pIn` as captured at start. `pOut` changes only in the cycle `done` is high, and it resets to 0x00.
- R6: Base cycle counts are 2 for immediate, 3 for direct page, and 4 for absolute, absolute + X and direct page + X. `done` is high for exactly one cycle, the cycle after the last counted cycle.
- R7: One cycle is added in every mode when `wideAcc` is high at start.
- R8: One cycle is added in both direct page modes when `dpReg[7:0]` is nonzero.
- R9: One cycle is added in absolute + X mode when `opLo + xIn[7:0]` carries out of 8 bits.
- R10: Direct page addresses are `dpReg + opLo` (plus `xIn` when indexed), modulo 2^16, in bank 0x00. The second byte of a wide read is at that address + 1, also modulo 2^16.
- R11: Absolute addresses are {`dataBank`,`opHi`,`opLo`} (plus `xIn` when indexed), modulo 2^24. The second byte of a wide read is at that address + 1.
- R12: A narrow memory read happens in the last counted cycle. A wide read takes the low byte in the next-to-last cycle and the high byte in the last cycle. `memRd` is high only in those cycles.
- R13: `instLen` in the `done` cycle is 2 for narrow immediate, 3 for wide immediate, 2 for both direct page modes, and 3 for both absolute modes.
- R14: `start` is ignored while an instruction is in progress, and operand inputs are captured only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction with the values presented this cycle |
| opcode | input | 8 | Opcode byte |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| accIn | input | 16 | Accumulator |
| xIn | input | 16 | Index register X |
| dpReg | input | 16 | Direct page register |
| dataBank | input | 8 | Data bank for absolute addresses |
| wideAcc | input | 1 | 1 = 16-bit accumulator |
| pIn | input | 8 | Status byte before the instruction |
| memData | input | 8 | Read data for `memAddr` |
| memAddr | output | 24 | Read address |
| memRd | output | 1 | Read strobe |
| done | output | 1 | One-cycle completion pulse |
| pOut | output | 8 | Status byte after the most recent instruction |
| instLen | output | 2 | Instruction length in bytes, valid with `done` |

## Verification
The unit's internal state is a cycle counter, a latched mode and a low-byte holding register. A counter with the wrong limit moves `done` and the read strobe off their cycles, so the per-cycle comparison reports it at the first instruction whose penalty rule is involved. A wrong latched mode or index shows up as a wrong `memAddr` in the first read cycle. A stale low byte or wrong operand width appears only in the N, V and Z bits of `pOut` in the `done` cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [2:0] {
    MODE_IMM,
    MODE_DP,
    MODE_ABS,
    MODE_ABSX,
    MODE_DPX
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  rdLo;
    logic  rdHi;
    logic  commit;
    mode_e mode;
    logic  wide;
  } strobe_t;

  localparam logic [7:0] OPC_IMM  = 8'h89;
  localparam logic [7:0] OPC_DP   = 8'h24;
  localparam logic [7:0] OPC_DPX  = 8'h34;
  localparam logic [7:0] OPC_ABS  = 8'h2C;
  localparam logic [7:0] OPC_ABSX = 8'h3C;

  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_Z = 1;

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic             wideIn,
  input  logic             dpLoNonzero,
  input  logic             pageCarry,
  output strobe_t          stb,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] FIRST_CYC = CNT_W'(2);

  mode_e            decMode;
  logic             opValid;
  logic [CNT_W-1:0] startTotal;

  mode_e            modeR;
  logic             wideR;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] loCyc;
  logic             lastCyc;
  logic             memMode;

  always_comb begin
    opValid = 1'b1;
    decMode = MODE_IMM;
    case (opcode)
      OPC_IMM:  decMode = MODE_IMM;
      OPC_DP:   decMode = MODE_DP;
      OPC_DPX:  decMode = MODE_DPX;
      OPC_ABS:  decMode = MODE_ABS;
      OPC_ABSX: decMode = MODE_ABSX;
      default:  opValid = 1'b0;
    endcase
  end

  function automatic logic [CNT_W-1:0] baseCycles(input mode_e m);
    case (m)
      MODE_IMM: return CNT_W'(2);
      MODE_DP:  return CNT_W'(3);
      default:  return CNT_W'(4);
    endcase
  endfunction

  always_comb begin
    startTotal = baseCycles(decMode)
               + CNT_W'(wideIn)
               + CNT_W'((decMode == MODE_DP || decMode == MODE_DPX) && dpLoNonzero)
               + CNT_W'(decMode == MODE_ABSX && pageCarry);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      modeR <= MODE_IMM;
      wideR <= 1'b0;
      cyc   <= '0;
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= lastCyc;
      if (stb.load) begin
        busy  <= 1'b1;
        modeR <= decMode;
        wideR <= wideIn;
        cyc   <= FIRST_CYC;
        total <= startTotal;
      end else if (busy) begin
        if (lastCyc) busy <= 1'b0;
        else         cyc  <= cyc + CNT_W'(1);
      end
    end
  end

  always_comb begin
    lastCyc    = busy && (cyc == total);
    loCyc      = wideR ? total - CNT_W'(1) : total;
    memMode    = (modeR != MODE_IMM);
    stb.load   = !busy && start && opValid;
    stb.rdLo   = busy && memMode && (cyc == loCyc);
    stb.rdHi   = busy && memMode && wideR && lastCyc;
    stb.commit = lastCyc;
    stb.mode   = modeR;
    stb.wide   = wideR;
  end

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: the counter never runs past its limit
  assert_cycle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc <= total));

  // R14: a start while busy does not reload the mode
  assert_start_ignored_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(modeR));

  // R12: the second byte is read only for a wide accumulator
  assert_hi_needs_wide_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdHi |-> wideIn || wideR);

endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [BYTE_W-1:0]   opLo,
  input  logic [BYTE_W-1:0]   opHi,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic [2*BYTE_W-1:0] xIn,
  input  logic [2*BYTE_W-1:0] dpReg,
  input  logic [BYTE_W-1:0]   dataBank,
  input  logic [BYTE_W-1:0]   pIn,
  input  logic [BYTE_W-1:0]   memData,
  output logic [3*BYTE_W-1:0] memAddr,
  output logic                memRd,
  output logic [BYTE_W-1:0]   pOut,
  output logic [1:0]          instLen,
  output logic                pageCarry,
  output logic                dpLoNonzero
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 3 * BYTE_W;

  logic [BYTE_W-1:0] opLoR, opHiR, bankR, pR, loReg;
  logic [WORD_W-1:0] accR, xR, dpR;

  logic              isDp, isIdx, isImm;
  logic [WORD_W-1:0] xAdd, dpEa, dpEa2;
  logic [ADDR_W-1:0] absEa, ea, ea2;
  logic [WORD_W-1:0] operand, masked;
  logic              nBit, vBit;
  logic [BYTE_W-1:0] nextP;
  logic [1:0]        nextLen;
  logic [BYTE_W:0]   lowSum;

  // start-time penalty inputs for the control
  always_comb begin
    lowSum      = {1'b0, opLo} + {1'b0, xIn[BYTE_W-1:0]};
    pageCarry   = lowSum[BYTE_W];
    dpLoNonzero = |dpReg[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opLoR <= '0; opHiR <= '0; bankR <= '0; pR <= '0;
      accR  <= '0; xR    <= '0; dpR   <= '0;
    end else if (stb.load) begin
      opLoR <= opLo;  opHiR <= opHi;  bankR <= dataBank; pR <= pIn;
      accR  <= accIn; xR    <= xIn;   dpR   <= dpReg;
    end
  end

  // effective address
  always_comb begin
    isDp  = (stb.mode == MODE_DP)   || (stb.mode == MODE_DPX);
    isIdx = (stb.mode == MODE_ABSX) || (stb.mode == MODE_DPX);
    isImm = (stb.mode == MODE_IMM);
    xAdd  = isIdx ? xR : '0;
    dpEa  = dpR + {{BYTE_W{1'b0}}, opLoR} + xAdd;
    dpEa2 = dpEa + WORD_W'(1);
    absEa = {bankR, opHiR, opLoR} + {{BYTE_W{1'b0}}, xAdd};
    ea    = isDp ? {{BYTE_W{1'b0}}, dpEa}  : absEa;
    ea2   = isDp ? {{BYTE_W{1'b0}}, dpEa2} : absEa + ADDR_W'(1);
    memAddr = stb.rdHi ? ea2 : ea;
    memRd   = stb.rdLo || stb.rdHi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         loReg <= '0;
    else if (stb.rdLo)  loReg <= memData;
  end

  // operand assembly and flag evaluation
  always_comb begin
    if (isImm)         operand = {opHiR, opLoR};
    else if (stb.wide) operand = {memData, loReg};
    else               operand = {{BYTE_W{1'b0}}, memData};

    if (stb.wide) begin
      masked = accR & operand;
      nBit   = operand[WORD_W-1];
      vBit   = operand[WORD_W-2];
    end else begin
      masked = {{BYTE_W{1'b0}}, accR[BYTE_W-1:0] & operand[BYTE_W-1:0]};
      nBit   = operand[BYTE_W-1];
      vBit   = operand[BYTE_W-2];
    end

    nextP         = pR;
    nextP[FLAG_Z] = (masked == '0);
    if (!isImm) begin
      nextP[FLAG_N] = nBit;
      nextP[FLAG_V] = vBit;
    end

    case (stb.mode)
      MODE_IMM:          nextLen = stb.wide ? 2'd3 : 2'd2;
      MODE_DP, MODE_DPX: nextLen = 2'd2;
      default:           nextLen = 2'd3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pOut    <= '0;
      instLen <= '0;
    end else if (stb.commit) begin
      pOut    <= nextP;
      instLen <= nextLen;
    end
  end

  // R12: high byte follows the low byte at the next address
  assert_hi_after_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdHi |-> $past(stb.rdLo) &&
      (memAddr[WORD_W-1:0] == $past(memAddr[WORD_W-1:0]) + WORD_W'(1)));

  // R4: immediate completion never touches memory
  assert_imm_noread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.commit && isImm) |-> !memRd);

  // R5: status only moves on a commit
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.commit |=> $stable(pOut));

  // R10: direct page reads stay in bank zero
  assert_dp_bank0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd && isDp) |-> (memAddr[ADDR_W-1:WORD_W] == '0));

endmodule

// File: rtl/bittest_unit.sv
module bittest_unit
  import bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  opLo,
  input  logic [7:0]  opHi,
  input  logic [15:0] accIn,
  input  logic [15:0] xIn,
  input  logic [15:0] dpReg,
  input  logic [7:0]  dataBank,
  input  logic        wideAcc,
  input  logic [7:0]  pIn,
  input  logic [7:0]  memData,
  output logic [23:0] memAddr,
  output logic        memRd,
  output logic        done,
  output logic [7:0]  pOut,
  output logic [1:0]  instLen
);

  strobe_t stb;
  logic    busy;
  logic    pageCarry;
  logic    dpLoNonzero;

  bt_ctrl #(.OPC_W(8), .CNT_W(3)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .opcode      (opcode),
    .wideIn      (wideAcc),
    .dpLoNonzero (dpLoNonzero),
    .pageCarry   (pageCarry),
    .stb         (stb),
    .busy        (busy),
    .done        (done)
  );

  bt_datapath #(.BYTE_W(8)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .opLo        (opLo),
    .opHi        (opHi),
    .accIn       (accIn),
    .xIn         (xIn),
    .dpReg       (dpReg),
    .dataBank    (dataBank),
    .pIn         (pIn),
    .memData     (memData),
    .memAddr     (memAddr),
    .memRd       (memRd),
    .pOut        (pOut),
    .instLen     (instLen),
    .pageCarry   (pageCarry),
    .dpLoNonzero (dpLoNonzero)
  );

  // R12: reads only happen inside an instruction
  assert_read_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    memRd |-> busy);

endmodule

// File: tb/sim_bittest_unit.sv
module sim_bittest_unit;

  logic        clk = 1'b0;
  logic        rst_n, start, wideAcc;
  logic [7:0]  opcode, opLo, opHi, dataBank, pIn, memData;
  logic [15:0] accIn, xIn, dpReg;
  logic [23:0] memAddr;
  logic        memRd, done;
  logic [7:0]  pOut;
  logic [1:0]  instLen;

  int vectors = 0;
  int fails   = 0;
  bit running = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  assign memData = memf(memAddr);

  bittest_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .opLo(opLo),
    .opHi(opHi), .accIn(accIn), .xIn(xIn), .dpReg(dpReg), .dataBank(dataBank),
    .wideAcc(wideAcc), .pIn(pIn), .memData(memData), .memAddr(memAddr),
    .memRd(memRd), .done(done), .pOut(pOut), .instLen(instLen)
  );

  // ---------------- reference model ----------------
  // modes: 0 imm, 1 dp, 2 abs, 3 abs+X, 4 dp+X, -1 not an instruction (R1)
  function automatic int modeOf(input logic [7:0] op);
    case (op)
      8'h89: return 0;
      8'h24: return 1;
      8'h2C: return 2;
      8'h3C: return 3;
      8'h34: return 4;
      default: return -1;
    endcase
  endfunction

  bit          mBusy = 0, mWide = 0, expDone = 0;
  int          mCyc = 0, mC = 0, mMode = 0, expLen = 0;
  logic [23:0] mEa = 0, mEa2 = 0;
  logic [15:0] mAcc = 0;
  logic [7:0]  mLo = 0, mHi = 0, mP = 0, expP = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; expDone = 0; expP = 8'h00; expLen = 0;
    end else begin
      running = 1;
      expDone = 0;
      if (mBusy) begin
        if (mCyc == mC) begin
          logic [15:0] opd, msk;
          if (mMode == 0) opd = {mHi, mLo};                 // R4
          else if (mWide) opd = {memf(mEa2), memf(mEa)};
          else            opd = {8'h00, memf(mEa)};
          msk = mWide ? (mAcc & opd) : {8'h00, mAcc[7:0] & opd[7:0]};
          expP = mP;                                        // R5
          expP[1] = (msk == 16'h0);                         // R2
          if (mMode != 0) begin                             // R3
            expP[7] = mWide ? opd[15] : opd[7];
            expP[6] = mWide ? opd[14] : opd[6];
          end
          expLen = (mMode == 0) ? (mWide ? 3 : 2) : ((mMode == 1 || mMode == 4) ? 2 : 3); // R13
          expDone = 1;
          mBusy = 0;
        end else mCyc++;
      end else if (start && modeOf(opcode) >= 0) begin      // R14: only when idle
        int base;
        mMode = modeOf(opcode); mWide = wideAcc; mAcc = accIn;
        mLo = opLo; mHi = opHi; mP = pIn;
        base = (mMode == 0) ? 2 : (mMode == 1) ? 3 : 4;    // R6
        mC = base + (wideAcc ? 1 : 0);                      // R7
        if ((mMode == 1 || mMode == 4) && dpReg[7:0] != 0) mC++;          // R8
        if (mMode == 3 && (int'(opLo) + int'(xIn[7:0])) > 255) mC++;      // R9
        if (mMode == 1 || mMode == 4) begin                 // R10
          int t;
          t = (int'(dpReg) + int'(opLo) + ((mMode == 4) ? int'(xIn) : 0)) % 65536;
          mEa  = 24'(t);
          mEa2 = 24'((t + 1) % 65536);
        end else begin                                      // R11
          int t;
          t = (int'({dataBank, opHi, opLo}) + ((mMode == 3) ? int'(xIn) : 0)) % 16777216;
          mEa  = 24'(t);
          mEa2 = 24'((t + 1) % 16777216);
        end
        mCyc = 2;
        mBusy = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running && rst_n && !finished) begin
      bit expRd;
      logic [23:0] expAddr;
      expRd = mBusy && mMode != 0 &&
              ((mWide && (mCyc == mC - 1 || mCyc == mC)) || (!mWide && mCyc == mC)); // R12
      expAddr = (mWide && mCyc == mC) ? mEa2 : mEa;
      chk(done == expDone, "R6 done timing", 32'(done), 32'(expDone));
      chk(memRd == expRd, "R12 read strobe", 32'(memRd), 32'(expRd));
      if (expRd)
        chk(memAddr == expAddr, (mMode == 1 || mMode == 4) ? "R10 dp address" : "R11 abs address",
            32'(memAddr), 32'(expAddr));
      chk(pOut == expP, "R2/R3/R5 status byte", 32'(pOut), 32'(expP));
      if (expDone)
        chk(int'(instLen) == expLen, "R13 length", 32'(instLen), 32'(expLen));
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [7:0] op, lo, hi, input logic [15:0] acc, x, dp,
                       input logic [7:0] bank, input logic wide, input logic [7:0] p);
    opcode = op; opLo = lo; opHi = hi; accIn = acc; xIn = x; dpReg = dp;
    dataBank = bank; wideAcc = wide; pIn = p;
  endtask

  task automatic go(input logic [7:0] op, lo, hi, input logic [15:0] acc, x, dp,
                    input logic [7:0] bank, input logic wide, input logic [7:0] p);
    drive(op, lo, hi, acc, x, dp, bank, wide, p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mBusy) @(negedge clk);   // returns in the done cycle
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    drive(8'h00, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 8'h00, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    // reset state (R5, R6, R12)
    chk(pOut == 8'h00, "R5 reset status", 32'(pOut), 32'h0);
    chk(done == 1'b0, "R6 reset done", 32'(done), 32'h0);
    chk(memRd == 1'b0, "R12 reset read", 32'(memRd), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: immediate narrow, N/V kept from pIn, Z set
    go(8'h89, 8'hF0, 8'h00, 16'h000F, 16'h0, 16'h0, 8'h00, 1'b0, 8'hC0);
    // R4 R7: immediate wide, Z clear
    go(8'h89, 8'h01, 8'h00, 16'h8001, 16'h0, 16'h0, 8'h00, 1'b1, 8'h3D);
    // R1 R3: direct page narrow, dp low byte zero
    go(8'h24, 8'h40, 8'h00, 16'h00FF, 16'h0, 16'h3300, 8'h7E, 1'b0, 8'h00);
    // R8 R7: direct page wide with nonzero dp low byte
    go(8'h24, 8'h10, 8'h00, 16'hFFFF, 16'h0, 16'h1201, 8'h7E, 1'b1, 8'hFF);
    // R10: direct page wrap at the top of bank 0, wide split across the wrap
    go(8'h24, 8'hFF, 8'h00, 16'h4000, 16'h0, 16'hFF00, 8'h55, 1'b1, 8'h00);
    // R11: absolute narrow in a data bank
    go(8'h2C, 8'h34, 8'h12, 16'h0000, 16'h0, 16'h0, 8'h7E, 1'b0, 8'h02);
    // R11 R9: absolute + X without carry
    go(8'h3C, 8'h10, 8'h80, 16'h00A5, 16'h0020, 16'h0, 8'h01, 1'b0, 8'h00);
    // R9 R7: absolute + X with page carry, wide
    go(8'h3C, 8'hF0, 8'h80, 16'h1234, 16'h0020, 16'h0, 8'h01, 1'b1, 8'h00);
    // R11: absolute + X carrying into the bank byte
    go(8'h3C, 8'hF0, 8'hFF, 16'hFFFF, 16'h0120, 16'h0, 8'h12, 1'b1, 8'h80);
    // R10 R8: direct page + X, both penalties off then on
    go(8'h34, 8'h05, 8'h00, 16'h0F0F, 16'h0105, 16'h2000, 8'h00, 1'b0, 8'h00);
    go(8'h34, 8'hFE, 8'h00, 16'hF00F, 16'hFFF0, 16'h00A1, 8'h00, 1'b1, 8'h41);
    // R1: unknown opcode ignored; status and strobes must stay put
    drive(8'h2D, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0, 8'h00, 1'b0, 8'hFF);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R14: start held through a run with changing inputs; restart only when idle
    drive(8'h2C, 8'h00, 8'h40, 16'h00FF, 16'h0, 16'h0, 8'h03, 1'b0, 8'h00);
    start = 1'b1;
    @(negedge clk);
    drive(8'h89, 8'h00, 8'h00, 16'h0000, 16'h0, 16'h0, 8'h00, 1'b0, 8'hFF);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (mBusy) @(negedge clk);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule